// File: doc/BRIEF.md
# Flash Block Lock-Bit Manager

This block holds one protect bit for each erase block of a flash array and a single master lock bit above them. Software changes these bits with two-write command pairs: a setup write followed by a confirm write whose data byte selects the operation. The three operations are: lock one block, lock the master bit, and release every block lock at once. A digital input reports that the elevated override voltage is present on the reset pin. While the master lock is set, any change to the block bits needs that override. Setting the master lock always needs it.

An accepted confirm starts a busy window of `BUSY_CYCLES` clocks, during which the ready output is low. At the end of the window the block either applies the change or records an error. The status byte carries a ready bit and three error flags. The error flags stay set until a clear-status write. The per-block protect vector is meant for the program and erase sequencers, which must refuse to touch a protected block.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset, `protect_o` and `master_lock_o` are 0, `ready_o` is 1 and `status_o` is 0x80.
- R2: A write of 0x60 followed by a write of 0x01 locks the block named by the top `$clog2(NUM_BLOCKS)` bits of the confirm address. This succeeds without override when the master lock is clear.
- R3: An accepted confirm write (0x01, 0xF1 or 0xD0 after 0x60) holds `ready_o` low for exactly `BUSY_CYCLES` cycles. `status_o[7]` always equals `ready_o`.
- R4: While the master lock is set, a block lock fails without override. A failed operation leaves the lock bits unchanged and sets `status_o[4]` (lock error) and `status_o[1]` (protect error). With override, the block lock succeeds.
- R5: Setup followed by 0xF1 sets `master_lock_o` only when the override is present. Without override it fails with bits 4 and 1 set. No command ever clears the master lock.
- R6: Setup followed by 0xD0 clears every block bit. It needs the override only while the master lock is set; otherwise it fails with bits 4 and 1 set.
- R7: A setup followed by any other confirm byte sets `status_o[5]` (sequence error) and `status_o[4]`. It starts no busy window and changes no lock bit.
- R8: A write of 0x50 while idle clears status bits 5, 4 and 1. Otherwise the error bits are sticky.
- R9: Writes that arrive while busy are ignored, including a new setup byte.
- R10: The override input is sampled only at the confirm write. A change to it during the busy window has no effect on the outcome.
- R11: While idle, any byte other than 0x60 or 0x50 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Command write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Write address; the upper bits select the block |
| wr_data_i | input | 8 | Command byte |
| hv_ok_i | input | 1 | Override voltage present |
| status_o | output | 8 | Status: bit7 ready, bit5 sequence error, bit4 lock error, bit1 protect error |
| ready_o | output | 1 | High when not busy |
| protect_o | output | NUM_BLOCKS | Per-block lock bits |
| master_lock_o | output | 1 | Master lock bit |

## Verification
Two cases are hardest to reach from the ports. The first is proving that a write during the busy window is discarded and not queued. The stimulus issues a setup byte mid-window, then sends a lone confirm byte once the block is idle. A leaked setup would turn that confirm into a lock, so the protect vector exposes any leak. The second is the override being sampled only at confirm: the bench drops or raises the override input inside the busy window and checks that the outcome follows the value present at the confirm write.

// File: rtl/flm_pkg.sv
package flm_pkg;
  localparam logic [7:0] OPC_SETUP    = 8'h60;
  localparam logic [7:0] OPC_CONF_BLK = 8'h01;
  localparam logic [7:0] OPC_CONF_MST = 8'hF1;
  localparam logic [7:0] OPC_CONF_CLR = 8'hD0;
  localparam logic [7:0] OPC_CLR_STAT = 8'h50;

  localparam int SB_READY = 7;
  localparam int SB_SEQ   = 5;
  localparam int SB_LOCK  = 4;
  localparam int SB_PROT  = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY} fsm_e;
  typedef enum logic [1:0] {LK_NONE, LK_BLOCK, LK_MASTER, LK_CLEAR} lk_op_e;
endpackage

// File: rtl/flm_decode.sv
module flm_decode
  import flm_pkg::*;
(
  input  logic [7:0] data_i,
  output logic       is_setup_o,
  output logic       is_clr_stat_o,
  output lk_op_e     conf_op_o
);
  assign is_setup_o    = (data_i == OPC_SETUP);
  assign is_clr_stat_o = (data_i == OPC_CLR_STAT);

  always_comb begin
    unique case (data_i)
      OPC_CONF_BLK: conf_op_o = LK_BLOCK;
      OPC_CONF_MST: conf_op_o = LK_MASTER;
      OPC_CONF_CLR: conf_op_o = LK_CLEAR;
      default:      conf_op_o = LK_NONE;
    endcase
  end
endmodule

// File: rtl/flm_timer.sv
module flm_timer #(
  parameter int CNT_MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // last busy cycle
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/flm_lock_array.sv
module flm_lock_array #(
  parameter int NUM_BLOCKS = 8,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_en_i,
  input  logic [BLK_W-1:0]      set_idx_i,
  input  logic                  clr_all_i,
  output logic [NUM_BLOCKS-1:0] locks_o
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        locks_o[b] <= 1'b0;
      else if (clr_all_i)                                 locks_o[b] <= 1'b0;
      else if (set_en_i && (set_idx_i == BLK_W'(b)))      locks_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
  import flm_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int ADDR_W      = 19,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  hv_ok_i,
  output logic [7:0]            status_o,
  output logic                  ready_o,
  output logic [NUM_BLOCKS-1:0] protect_o,
  output logic                  master_lock_o
);
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  fsm_e             state_q;
  lk_op_e           op_q;
  logic [BLK_W-1:0] idx_q;
  logic             allow_q;
  logic             master_q;
  logic             seq_err_q, lock_err_q, prot_err_q;

  logic             is_setup, is_clr_stat;
  lk_op_e           conf_op;
  logic             allow_now;
  logic             accept_conf;
  logic             done;
  logic [BLK_W-1:0] blk_idx;
  logic             unused_addr;

  assign blk_idx     = wr_addr_i[ADDR_W-1 -: BLK_W];
  assign unused_addr = ^wr_addr_i;

  flm_decode i_dec (
    .data_i        (wr_data_i),
    .is_setup_o    (is_setup),
    .is_clr_stat_o (is_clr_stat),
    .conf_op_o     (conf_op)
  );

  // override sampled at the confirm write only
  always_comb begin
    unique case (conf_op)
      LK_MASTER: allow_now = hv_ok_i;
      LK_BLOCK,
      LK_CLEAR:  allow_now = !master_q || hv_ok_i;
      default:   allow_now = 1'b0;
    endcase
  end

  assign accept_conf = (state_q == ST_SETUP) && wr_en_i && (conf_op != LK_NONE);

  flm_timer #(.CNT_MAX(BUSY_CYCLES)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept_conf),
    .done_o (done)
  );

  logic fin_ok;
  assign fin_ok = (state_q == ST_BUSY) && done && allow_q;

  flm_lock_array #(.NUM_BLOCKS(NUM_BLOCKS)) i_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (fin_ok && (op_q == LK_BLOCK)),
    .set_idx_i (idx_q),
    .clr_all_i (fin_ok && (op_q == LK_CLEAR)),
    .locks_o   (protect_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= LK_NONE;
      idx_q      <= '0;
      allow_q    <= 1'b0;
      master_q   <= 1'b0;
      seq_err_q  <= 1'b0;
      lock_err_q <= 1'b0;
      prot_err_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (wr_en_i) begin
          if (is_setup) state_q <= ST_SETUP;
          else if (is_clr_stat) begin
            seq_err_q  <= 1'b0;
            lock_err_q <= 1'b0;
            prot_err_q <= 1'b0;
          end
        end
        ST_SETUP: if (wr_en_i) begin
          if (conf_op != LK_NONE) begin
            state_q <= ST_BUSY;
            op_q    <= conf_op;
            idx_q   <= blk_idx;
            allow_q <= allow_now;
          end else begin
            state_q    <= ST_IDLE;
            seq_err_q  <= 1'b1;
            lock_err_q <= 1'b1;
          end
        end
        ST_BUSY: if (done) begin
          state_q <= ST_IDLE;
          if (allow_q) begin
            if (op_q == LK_MASTER) master_q <= 1'b1;
          end else begin
            lock_err_q <= 1'b1;
            prot_err_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o       = (state_q != ST_BUSY);
  assign master_lock_o = master_q;

  always_comb begin
    status_o          = '0;
    status_o[SB_READY] = ready_o;
    status_o[SB_SEQ]   = seq_err_q;
    status_o[SB_LOCK]  = lock_err_q;
    status_o[SB_PROT]  = prot_err_q;
  end
endmodule

// File: rtl/flm_chk.sv
module flm_chk
  import flm_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int BUSY_CYCLES = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic [7:0]            wr_data_i,
  input logic [7:0]            status_o,
  input logic                  ready_o,
  input logic [NUM_BLOCKS-1:0] protect_o,
  input logic                  master_lock_o
);
  int unsigned low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt_q <= 0;
    else if (!ready_o) low_cnt_q <= low_cnt_q + 1;
    else               low_cnt_q <= 0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_cnt_q == BUSY_CYCLES));

  // R3
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(wr_en_i));

  // R9
  lock_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(protect_o) |-> $rose(ready_o));

  // R5
  master_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(master_lock_o) |-> $rose(ready_o));

  // R5
  master_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(master_lock_o));

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(status_o[SB_LOCK]) || $fell(status_o[SB_PROT]) || $fell(status_o[SB_SEQ]))
      |-> $past(wr_en_i && (wr_data_i == OPC_CLR_STAT)));
endmodule

bind flash_lock_mgr flm_chk #(
  .NUM_BLOCKS  (NUM_BLOCKS),
  .BUSY_CYCLES (BUSY_CYCLES)
) i_flm_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .status_o      (status_o),
  .ready_o       (ready_o),
  .protect_o     (protect_o),
  .master_lock_o (master_lock_o)
);

// File: tb/test_flash_lock_mgr.sv
`timescale 1ns/1ps
module test_flash_lock_mgr;
  localparam int NB = 8;
  localparam int AW = 19;
  localparam int BC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          hv = 1'b0;
  logic [7:0]    status;
  logic          ready;
  logic [NB-1:0] protect;
  logic          master;

  always #5 clk = ~clk;

  flash_lock_mgr #(.NUM_BLOCKS(NB), .ADDR_W(AW), .BUSY_CYCLES(BC)) i_flash_lock_mgr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hv_ok_i(hv), .status_o(status), .ready_o(ready),
    .protect_o(protect), .master_lock_o(master)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit [NB-1:0] m_locks;
  bit m_master, m_seq, m_lerr, m_perr, m_ok;
  int m_mode, m_left, m_kind, m_idx;

  function automatic bit [7:0] m_status();
    return {(m_mode != 2), 1'b0, m_seq, m_lerr, 2'b00, m_perr, 1'b0};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locks = '0; m_master = 0; m_seq = 0; m_lerr = 0; m_perr = 0;
      m_mode = 0; m_left = 0; m_kind = 0; m_idx = 0; m_ok = 0;
    end else begin
      cycles++;
      if (m_mode == 2) begin
        m_left--;
        if (m_left == 0) begin
          m_mode = 0;
          if (!m_ok) begin m_lerr = 1; m_perr = 1; end
          else if (m_kind == 1) m_locks[m_idx] = 1'b1;
          else if (m_kind == 2) m_master = 1;
          else m_locks = '0;
        end
      end else if (m_mode == 1 && wr_en) begin
        m_kind = (wr_data == 8'h01) ? 1 : (wr_data == 8'hF1) ? 2 : (wr_data == 8'hD0) ? 3 : 0;
        if (m_kind == 0) begin m_seq = 1; m_lerr = 1; m_mode = 0; end
        else begin
          m_idx  = int'(wr_addr[AW-1 -: 3]);
          m_ok   = (m_kind == 2) ? hv : (!m_master || hv);
          m_mode = 2;
          m_left = BC;
        end
      end else if (m_mode == 0 && wr_en) begin
        if (wr_data == 8'h60) m_mode = 1;
        else if (wr_data == 8'h50) begin m_seq = 0; m_lerr = 0; m_perr = 0; end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(protect == m_locks, "R2 model protect", int'(protect), int'(m_locks));
    chk(master == m_master, "R5 model master", int'(master), int'(m_master));
    chk(status == m_status(), "R3 model status", int'(status), int'(m_status()));
    chk(ready == status[7], "R3 ready mirrors bit7", int'(ready), int'(status[7]));
  end

  task automatic wr(input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic logic [AW-1:0] blk(input int b);
    return {3'(b), 16'h1234};
  endfunction

  bit finished = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(protect == 0 && master == 0, "R1 reset locks", int'(protect), 0);
    chk(status == 8'h80 && ready, "R1 reset status", int'(status), 'h80);

    wr(8'h60, blk(3)); wr(8'h01, blk(3));
    chk(!ready, "R3 busy after confirm", int'(ready), 0);
    wait_ready(n);
    chk(n == BC, "R3 busy length", n, BC);
    chk(protect == 8'h08, "R2 block 3 locked", int'(protect), 'h08);

    wr(8'h60, blk(0)); wr(8'h77, blk(0));
    chk(status == 8'hB0 && ready, "R7 bad confirm", int'(status), 'hB0);
    chk(protect == 8'h08, "R7 locks unchanged", int'(protect), 'h08);
    wr(8'h22, blk(0));
    chk(status == 8'hB0, "R11 stray byte ignored", int'(status), 'hB0);
    wr(8'h01, blk(6));
    chk(protect == 8'h08 && ready, "R11 lone confirm ignored", int'(protect), 'h08);
    wr(8'h50, blk(0));
    chk(status == 8'h80, "R8 status cleared", int'(status), 'h80);

    hv = 0;
    wr(8'h60, blk(0)); wr(8'hF1, blk(2));
    wait_ready(n);
    chk(status == 8'h92 && !master, "R5 master needs override", int'(status), 'h92);
    @(negedge clk);
    chk(status == 8'h92, "R8 errors sticky", int'(status), 'h92);
    wr(8'h50, blk(0));
    hv = 1;
    wr(8'h60, blk(0)); wr(8'hF1, blk(2));
    hv = 0;
    wait_ready(n);
    chk(master == 1 && status == 8'h80, "R5 master set with override", int'(master), 1);

    wr(8'h60, blk(5)); wr(8'h01, blk(5));
    wait_ready(n);
    chk(status == 8'h92 && protect == 8'h08, "R4 block lock refused", int'(protect), 'h08);
    wr(8'h50, blk(0));
    hv = 1;
    wr(8'h60, blk(5)); wr(8'h01, blk(5));
    hv = 0;
    wait_ready(n);
    chk(protect == 8'h28, "R4 block lock with override", int'(protect), 'h28);

    wr(8'h60, blk(0)); wr(8'hD0, blk(0));
    wait_ready(n);
    chk(status == 8'h92 && protect == 8'h28, "R6 clear refused", int'(protect), 'h28);
    wr(8'h50, blk(0));
    hv = 1;
    wr(8'h60, blk(0)); wr(8'hD0, blk(0));
    hv = 0;
    wait_ready(n);
    chk(protect == 0 && status == 8'h80, "R6 R10 clear with override", int'(protect), 0);

    hv = 1;
    wr(8'h60, blk(1)); wr(8'h01, blk(1));
    wr(8'h60, blk(0));
    hv = 0;
    wait_ready(n);
    chk(protect == 8'h02, "R9 lock during busy", int'(protect), 'h02);
    wr(8'h01, blk(7));
    chk(protect == 8'h02 && ready, "R9 busy setup discarded", int'(protect), 'h02);

    wr(8'h60, blk(4)); wr(8'h01, blk(4));
    hv = 1;
    wait_ready(n);
    hv = 0;
    chk(status == 8'h92 && protect == 8'h02, "R10 late override ignored", int'(status), 'h92);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule